// File: doc/BRIEF.md
# Flash Mailbox Command Validator

This block sits between a mailbox command queue and a quad SPI flash engine. A client presents one whole command in a single cycle: an opcode, the number of argument words it carried, its client number, the first two argument words and a flag that says whether device configuration is running. The validator checks that command against the ownership state and the rules for that opcode. One cycle later it returns a response code. When the command is a flash access that passes every check, it also sends a decoded request to the flash engine.

Only one client may own the flash at a time. A client takes ownership with an open command and gives it up with a close command. Every other flash command needs ownership. The block also keeps the selected chip-select index, which starts at device 0.

The engine request carries:
- an operation code;
- a word address (the byte address shifted right by two);
- a word count;
- a device opcode byte for register and raw-opcode commands;
- the selected chip select.

Data words beyond the first two arguments never enter the block. Only their number, given by the command length, is checked.

Top module: `flash_cmd_validator`

## Requirements
- R1: Every accepted command (`cmd_valid` high) produces exactly one `rsp_valid` pulse on the next cycle, and no response appears without a command. The recognised opcodes are 0x32 open, 0x33 close, 0x34 select device, 0x3A read, 0x39 write, 0x38 erase, 0x35 register read, 0x36 register write and 0x37 raw opcode. Any other opcode answers 6.
- R2: Open with length 0 is granted (code 0) when no other client owns the flash and `cfg_busy` is low. A client that already owns the flash may open again and is granted. Otherwise open answers 3.
- R3: Any recognised command other than open, from a client that is not the owner, answers 4. A close from the owner answers 0 and frees the flash, after which another client can open.
- R4: The argument length must be exactly: 0 for open and close; 1 for select device and raw opcode; 2 for read, erase and register read; 2 plus the word count (`cmd_arg1`) for write; 2 plus ceil(`cmd_arg1`/4) for register write. Any other length answers 5.
- R5: Read and write answer 3 while `cfg_busy` is high.
- R6: Read and write word counts must lie in 1..1024. Any other count answers 2.
- R7: Read and write byte addresses (`cmd_arg0`) must have bits [1:0] equal to zero. Otherwise they answer 1.
- R8: Erase counts must be 0x400, 0x2000 or 0x4000 words, or the command answers 2. The start byte address must be aligned to 4 KB, 32 KB or 64 KB respectively, or the command answers 1. A passing erase is forwarded with op 2 and the given count.
- R9: Select device takes the device index from `cmd_arg0[31:28]` and ignores bits [27:0]. An index above 0 answers 7 and leaves the selection unchanged. The selection resets to 0, persists across commands and is driven on `req_cs` with every forwarded request.
- R10: Register read and register write need a byte count (`cmd_arg1`) in 1..8, or they answer 2. A passing command is forwarded with op 3 (read) or op 4 (write). Its `req_count` is the byte count rounded up to whole words, and `req_devop` is `cmd_arg0[7:0]`.
- R11: A forwarded read (op 0) or write (op 1) carries `req_waddr` = `cmd_arg0[31:2]` and `req_count` = `cmd_arg1`. A raw opcode command is forwarded as op 5 with `req_devop` = `cmd_arg0[7:0]`. `req_valid` is high only together with a code-0 response.
- R12: When several faults apply, one code is reported, chosen in this order:
  1. unknown opcode;
  2. ownership (for open, length is checked before availability);
  3. length;
  4. configuration busy;
  5. size;
  6. alignment;
  7. bad device index.
- R13: After reset there is no owner, `rsp_valid` and `req_valid` are low, and `rsp_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_opcode | input | 8 | Command opcode |
| cmd_len | input | 11 | Number of argument words in the command |
| cmd_client | input | 2 | Issuing client number |
| cmd_arg0 | input | 32 | First argument word (address, device index or device opcode) |
| cmd_arg1 | input | 32 | Second argument word (word count or byte count) |
| cfg_busy | input | 1 | Device configuration in progress |
| rsp_valid | output | 1 | Response code valid |
| rsp_code | output | 4 | 0 OK, 1 misaligned, 2 bad size, 3 busy, 4 not owner, 5 length, 6 bad opcode, 7 bad device index |
| req_valid | output | 1 | Validated request to the flash engine |
| req_op | output | 3 | 0 read, 1 write, 2 erase, 3 register read, 4 register write, 5 raw opcode |
| req_waddr | output | 30 | Word address |
| req_count | output | 16 | Word count |
| req_devop | output | 8 | Device opcode byte |
| req_cs | output | 2 | Selected chip select |

## Verification
The hardest outcome to reach from the ports is a forwarded erase or a full-size transfer. It needs four things at once: the issuing client must be the current owner, configuration must be idle, the length must be exact, and the count and address must meet a boundary rule. Random commands almost never line all of these up.

The stimulus therefore works in three ways:
- It draws the client from the model's current owner most of the time.
- It fills in the nominal length for the chosen opcode in most draws.
- It picks counts and addresses from sets weighted toward the boundaries: counts 0, 1, 1024, 1025 and the three erase sizes, and addresses aligned to 64 KB or 4 KB, aligned to a word, or left unaligned.

Directed sequences cover ownership handover and the check-priority cases.

// File: rtl/flash_val_pkg.sv
// Shared opcodes, response codes and request operation encoding for the
// flash command validator. Assumes 8-bit opcodes and 32-bit argument words.
package flash_val_pkg;

    localparam logic [7:0] OPC_OPEN    = 8'h32;
    localparam logic [7:0] OPC_CLOSE   = 8'h33;
    localparam logic [7:0] OPC_SEL_DEV = 8'h34;
    localparam logic [7:0] OPC_REG_RD  = 8'h35;
    localparam logic [7:0] OPC_REG_WR  = 8'h36;
    localparam logic [7:0] OPC_RAW_OP  = 8'h37;
    localparam logic [7:0] OPC_ERASE   = 8'h38;
    localparam logic [7:0] OPC_WRITE   = 8'h39;
    localparam logic [7:0] OPC_READ    = 8'h3A;

    typedef enum logic [3:0] {
        RC_OK        = 4'd0,
        RC_MISALIGN  = 4'd1,
        RC_SIZE      = 4'd2,
        RC_BUSY      = 4'd3,
        RC_NOT_OWNER = 4'd4,
        RC_LENGTH    = 4'd5,
        RC_BAD_OPC   = 4'd6,
        RC_BAD_DEV   = 4'd7
    } rsp_code_e;

    typedef enum logic [2:0] {
        FOP_READ   = 3'd0,
        FOP_WRITE  = 3'd1,
        FOP_ERASE  = 3'd2,
        FOP_REG_RD = 3'd3,
        FOP_REG_WR = 3'd4,
        FOP_RAW    = 3'd5
    } flash_op_e;

    // Legal erase sizes in words; alignment in bytes is four times each.
    localparam int N_ERASE = 3;
    localparam logic [31:0] ERASE_WORDS [N_ERASE] = '{32'h400, 32'h2000, 32'h4000};

endpackage

// File: rtl/flash_owner_track.sv
// Holds which client owns the flash and the selected chip-select index.
// Assumes grant and release are never asserted together (the rule checker
// raises at most one of them per command).
module flash_owner_track #(
    parameter int CLIENT_W = 2,
    parameter int CS_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant,
    input  logic                release_own,
    input  logic [CLIENT_W-1:0] client,
    input  logic                cs_set,
    input  logic [CS_W-1:0]     cs_new,
    output logic                owner_valid,
    output logic [CLIENT_W-1:0] owner_id,
    output logic [CS_W-1:0]     cs_sel
);

    // Ownership register: set by a granted open, cleared by a close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_valid <= 1'b0;
            owner_id    <= '0;
        end else if (grant) begin
            owner_valid <= 1'b1;
            owner_id    <= client;
        end else if (release_own) begin
            owner_valid <= 1'b0;
        end
    end

    // Chip-select register: defaults to device 0, changes only on a valid select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sel <= '0;
        end else if (cs_set) begin
            cs_sel <= cs_new;
        end
    end

endmodule

// File: rtl/flash_rule_check.sv
// Combinational rule evaluation for one command. Applies checks in the fixed
// priority order: opcode, ownership, length, configuration busy, size,
// alignment, device index. Assumes a 32-bit argument word and ADDR_W <= 32.
module flash_rule_check
    import flash_val_pkg::*;
#(
    parameter int CLIENT_W         = 2,
    parameter int CS_W             = 2,
    parameter int LEN_W            = 11,
    parameter int ADDR_W           = 32,
    parameter int CNT_W            = 16,
    parameter int MAX_XFER_WORDS   = 1024,
    parameter int MAX_DEVREG_BYTES = 8,
    parameter int MAX_CS_IDX       = 0
) (
    input  logic [7:0]          opcode,
    input  logic [LEN_W-1:0]    len,
    input  logic [CLIENT_W-1:0] client,
    input  logic [31:0]         arg0,
    input  logic [31:0]         arg1,
    input  logic                cfg_busy,
    input  logic                owner_valid,
    input  logic [CLIENT_W-1:0] owner_id,
    output rsp_code_e           code,
    output logic                fwd,
    output flash_op_e           op,
    output logic [ADDR_W-3:0]   waddr,
    output logic [CNT_W-1:0]    count,
    output logic [7:0]          devop,
    output logic                grant,
    output logic                release_own,
    output logic                cs_set,
    output logic [CS_W-1:0]     cs_new
);

    localparam int EXT_W = 33;

    logic               is_owner;
    logic [EXT_W-1:0]   len_ext;
    logic [EXT_W-1:0]   dev_words;
    logic               wr_len_ok;
    logic               wreg_len_ok;
    logic               xfer_size_bad;
    logic               reg_size_bad;
    logic               word_misalign;
    logic               dev_idx_bad;
    logic [N_ERASE-1:0] erase_hit;
    logic [N_ERASE-1:0] erase_alg;
    logic               erase_size_ok;
    logic               erase_aligned;

    assign is_owner      = owner_valid && (owner_id == client);
    assign len_ext       = EXT_W'(len);
    assign dev_words     = ({1'b0, arg1} + EXT_W'(3)) >> 2;
    assign wr_len_ok     = (len_ext == ({1'b0, arg1} + EXT_W'(2)));
    assign wreg_len_ok   = (len_ext == (dev_words + EXT_W'(2)));
    assign xfer_size_bad = (arg1 == 32'd0) || (arg1 > 32'(MAX_XFER_WORDS));
    assign reg_size_bad  = (arg1 == 32'd0) || (arg1 > 32'(MAX_DEVREG_BYTES));
    assign word_misalign = (arg0[1:0] != 2'b00);
    assign dev_idx_bad   = (32'(arg0[31:28]) > 32'(MAX_CS_IDX));

    // One matcher per legal erase size: size hit and byte-boundary alignment.
    for (genvar g = 0; g < N_ERASE; g++) begin : g_erase
        assign erase_hit[g] = (arg1 == ERASE_WORDS[g]);
        assign erase_alg[g] = ((arg0 & ((ERASE_WORDS[g] << 2) - 32'd1)) == 32'd0);
    end
    assign erase_size_ok = |erase_hit;
    assign erase_aligned = |(erase_hit & erase_alg);

    // Decide the response code, the forwarded request and the state updates.
    always_comb begin
        code        = RC_OK;
        fwd         = 1'b0;
        op          = FOP_READ;
        waddr       = arg0[ADDR_W-1:2];
        count       = CNT_W'(arg1);
        devop       = 8'd0;
        grant       = 1'b0;
        release_own = 1'b0;
        cs_set      = 1'b0;
        cs_new      = CS_W'(arg0[31:28]);
        unique case (opcode)
            OPC_OPEN: begin
                if (len_ext != '0)                          code = RC_LENGTH;
                else if ((owner_valid && !is_owner) || cfg_busy) code = RC_BUSY;
                else                                        grant = 1'b1;
            end
            OPC_CLOSE: begin
                if (!is_owner)          code = RC_NOT_OWNER;
                else if (len_ext != '0) code = RC_LENGTH;
                else                    release_own = 1'b1;
            end
            OPC_SEL_DEV: begin
                if (!is_owner)                   code = RC_NOT_OWNER;
                else if (len_ext != EXT_W'(1))   code = RC_LENGTH;
                else if (dev_idx_bad)            code = RC_BAD_DEV;
                else                             cs_set = 1'b1;
            end
            OPC_READ, OPC_WRITE: begin
                op = (opcode == OPC_READ) ? FOP_READ : FOP_WRITE;
                if (!is_owner) code = RC_NOT_OWNER;
                else if ((opcode == OPC_READ) ? (len_ext != EXT_W'(2)) : !wr_len_ok)
                    code = RC_LENGTH;
                else if (cfg_busy)      code = RC_BUSY;
                else if (xfer_size_bad) code = RC_SIZE;
                else if (word_misalign) code = RC_MISALIGN;
                else                    fwd = 1'b1;
            end
            OPC_ERASE: begin
                op = FOP_ERASE;
                if (!is_owner)                 code = RC_NOT_OWNER;
                else if (len_ext != EXT_W'(2)) code = RC_LENGTH;
                else if (!erase_size_ok)       code = RC_SIZE;
                else if (!erase_aligned)       code = RC_MISALIGN;
                else                           fwd = 1'b1;
            end
            OPC_REG_RD, OPC_REG_WR: begin
                op    = (opcode == OPC_REG_RD) ? FOP_REG_RD : FOP_REG_WR;
                waddr = '0;
                count = CNT_W'(dev_words);
                devop = arg0[7:0];
                if (!is_owner) code = RC_NOT_OWNER;
                else if ((opcode == OPC_REG_RD) ? (len_ext != EXT_W'(2)) : !wreg_len_ok)
                    code = RC_LENGTH;
                else if (reg_size_bad) code = RC_SIZE;
                else                   fwd = 1'b1;
            end
            OPC_RAW_OP: begin
                op    = FOP_RAW;
                waddr = '0;
                count = '0;
                devop = arg0[7:0];
                if (!is_owner)                 code = RC_NOT_OWNER;
                else if (len_ext != EXT_W'(1)) code = RC_LENGTH;
                else                           fwd = 1'b1;
            end
            default: code = RC_BAD_OPC;
        endcase
    end

endmodule

// File: rtl/flash_cmd_validator.sv
// Top of the flash command validator. Evaluates one command per cycle,
// updates ownership and chip select, and registers the response and the
// forwarded request so that both appear one cycle after cmd_valid.
// Assumes a command is presented complete in one cycle.
module flash_cmd_validator
    import flash_val_pkg::*;
#(
    parameter int CLIENT_W         = 2,
    parameter int CS_W             = 2,
    parameter int LEN_W            = 11,
    parameter int ADDR_W           = 32,
    parameter int CNT_W            = 16,
    parameter int MAX_XFER_WORDS   = 1024,
    parameter int MAX_DEVREG_BYTES = 8,
    parameter int MAX_CS_IDX       = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_opcode,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [CLIENT_W-1:0] cmd_client,
    input  logic [31:0]         cmd_arg0,
    input  logic [31:0]         cmd_arg1,
    input  logic                cfg_busy,
    output logic                rsp_valid,
    output logic [3:0]          rsp_code,
    output logic                req_valid,
    output logic [2:0]          req_op,
    output logic [ADDR_W-3:0]   req_waddr,
    output logic [CNT_W-1:0]    req_count,
    output logic [7:0]          req_devop,
    output logic [CS_W-1:0]     req_cs
);

    rsp_code_e           chk_code;
    logic                chk_fwd;
    flash_op_e           chk_op;
    logic [ADDR_W-3:0]   chk_waddr;
    logic [CNT_W-1:0]    chk_count;
    logic [7:0]          chk_devop;
    logic                chk_grant;
    logic                chk_release;
    logic                chk_cs_set;
    logic [CS_W-1:0]     chk_cs_new;
    logic                owner_valid;
    logic [CLIENT_W-1:0] owner_id;
    logic [CS_W-1:0]     cs_sel;

    flash_rule_check #(
        .CLIENT_W(CLIENT_W), .CS_W(CS_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .MAX_XFER_WORDS(MAX_XFER_WORDS),
        .MAX_DEVREG_BYTES(MAX_DEVREG_BYTES), .MAX_CS_IDX(MAX_CS_IDX)
    ) i_rules (
        .opcode(cmd_opcode), .len(cmd_len), .client(cmd_client),
        .arg0(cmd_arg0), .arg1(cmd_arg1), .cfg_busy(cfg_busy),
        .owner_valid(owner_valid), .owner_id(owner_id),
        .code(chk_code), .fwd(chk_fwd), .op(chk_op), .waddr(chk_waddr),
        .count(chk_count), .devop(chk_devop), .grant(chk_grant),
        .release_own(chk_release), .cs_set(chk_cs_set), .cs_new(chk_cs_new)
    );

    flash_owner_track #(.CLIENT_W(CLIENT_W), .CS_W(CS_W)) i_owner (
        .clk(clk), .rst_n(rst_n),
        .grant(cmd_valid && chk_grant),
        .release_own(cmd_valid && chk_release),
        .client(cmd_client),
        .cs_set(cmd_valid && chk_cs_set),
        .cs_new(chk_cs_new),
        .owner_valid(owner_valid), .owner_id(owner_id), .cs_sel(cs_sel)
    );

    // Response register: one pulse per command, code held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= 4'd0;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) rsp_code <= chk_code;
        end
    end

    // Request register: loaded only for commands that pass every rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_op    <= 3'd0;
            req_waddr <= '0;
            req_count <= '0;
            req_devop <= 8'd0;
            req_cs    <= '0;
        end else begin
            req_valid <= cmd_valid && chk_fwd;
            if (cmd_valid && chk_fwd) begin
                req_op    <= chk_op;
                req_waddr <= chk_waddr;
                req_count <= chk_count;
                req_devop <= chk_devop;
                req_cs    <= cs_sel;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_validator_chk.sv
// Assertion checker for the flash command validator, bound to every instance.
// Observes ports plus the ownership state held by the owner tracker.
module flash_cmd_validator_chk
    import flash_val_pkg::*;
#(
    parameter int CLIENT_W       = 2,
    parameter int CS_W           = 2,
    parameter int CNT_W          = 16,
    parameter int MAX_XFER_WORDS = 1024,
    parameter int MAX_CS_IDX     = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [7:0]          cmd_opcode,
    input logic [CLIENT_W-1:0] cmd_client,
    input logic                cfg_busy,
    input logic                rsp_valid,
    input logic [3:0]          rsp_code,
    input logic                req_valid,
    input logic [2:0]          req_op,
    input logic [CNT_W-1:0]    req_count,
    input logic [CS_W-1:0]     req_cs,
    input logic                owner_valid,
    input logic [CLIENT_W-1:0] owner_id
);

    // R1
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R1
    no_idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // R11
    req_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (rsp_valid && rsp_code == 4'(RC_OK)));

    // R3
    foreign_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && owner_valid && cmd_client != owner_id) |=> rsp_code != 4'(RC_OK));

    // R5
    cfg_blocks_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cfg_busy && (cmd_opcode == OPC_READ || cmd_opcode == OPC_WRITE))
        |=> !req_valid);

    // R6
    xfer_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'(FOP_READ) || req_op == 3'(FOP_WRITE)))
        |-> (req_count != '0 && 32'(req_count) <= 32'(MAX_XFER_WORDS)));

    // R8
    erase_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'(FOP_ERASE))
        |-> (32'(req_count) == 32'h400 || 32'(req_count) == 32'h2000 || 32'(req_count) == 32'h4000));

    // R9
    cs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> 32'(req_cs) <= 32'(MAX_CS_IDX));

endmodule

bind flash_cmd_validator flash_cmd_validator_chk #(
    .CLIENT_W(CLIENT_W), .CS_W(CS_W), .CNT_W(CNT_W),
    .MAX_XFER_WORDS(MAX_XFER_WORDS), .MAX_CS_IDX(MAX_CS_IDX)
) i_flash_cmd_validator_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
    .cmd_client(cmd_client), .cfg_busy(cfg_busy), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .req_valid(req_valid), .req_op(req_op),
    .req_count(req_count), .req_cs(req_cs), .owner_valid(owner_valid),
    .owner_id(owner_id)
);

// File: tb/test_flash_cmd_validator.sv
`timescale 1ns/1ps
module test_flash_cmd_validator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = 8'd0;
    logic [10:0] cmd_len = 11'd0;
    logic [1:0]  cmd_client = 2'd0;
    logic [31:0] cmd_arg0 = 32'd0;
    logic [31:0] cmd_arg1 = 32'd0;
    logic        cfg_busy = 1'b0;
    logic        rsp_valid;
    logic [3:0]  rsp_code;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [29:0] req_waddr;
    logic [15:0] req_count;
    logic [7:0]  req_devop;
    logic [1:0]  req_cs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state kept from the requirements
    bit       m_owner_v = 0;
    bit [1:0] m_owner = 0;
    bit [1:0] m_cs = 0;

    always #2.5 clk = ~clk;

    flash_cmd_validator i_flash_cmd_validator (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_len(cmd_len), .cmd_client(cmd_client), .cmd_arg0(cmd_arg0),
        .cmd_arg1(cmd_arg1), .cfg_busy(cfg_busy), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .req_valid(req_valid), .req_op(req_op),
        .req_waddr(req_waddr), .req_count(req_count), .req_devop(req_devop),
        .req_cs(req_cs)
    );

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected outcome of a command from the requirement text.
    task automatic model(input logic [7:0] opc, input logic [10:0] len, input logic [1:0] cl,
                         input logic [31:0] a0, input logic [31:0] a1, input logic busy,
                         output int code, output bit fwd, output int eop,
                         output longint ewa, output longint ecnt, output longint edev,
                         output string tag);
        bit own;
        longint l, n, pw, want;
        own = m_owner_v && (m_owner == cl);
        l = longint'(len); n = longint'(a1); pw = (n + 3) / 4;
        code = 0; fwd = 0; eop = 0; ewa = 0; ecnt = 0; edev = 0; tag = "R11";
        if (!(opc inside {8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39, 8'h3A})) begin
            code = 6; tag = "R1"; return;
        end
        if (opc == 8'h32) begin
            tag = "R2";
            if (l != 0) begin code = 5; tag = "R4"; end
            else if ((m_owner_v && !own) || busy) code = 3;
            return;
        end
        if (!own) begin code = 4; tag = "R3"; return; end
        case (opc)
            8'h33:               want = 0;
            8'h34, 8'h37:        want = 1;
            8'h39:               want = 2 + n;
            8'h36:               want = 2 + pw;
            default:             want = 2;
        endcase
        if (l != want) begin code = 5; tag = "R4"; return; end
        case (opc)
            8'h33: tag = "R3";
            8'h34: begin tag = "R9"; if (a0[31:28] != 0) code = 7; end
            8'h3A, 8'h39: begin
                if (busy) begin code = 3; tag = "R5"; end
                else if (n == 0 || n > 1024) begin code = 2; tag = "R6"; end
                else if (a0[1:0] != 0) begin code = 1; tag = "R7"; end
                else begin fwd = 1; eop = (opc == 8'h3A) ? 0 : 1; ewa = longint'(a0 >> 2); ecnt = n; end
            end
            8'h38: begin
                tag = "R8";
                if (!(n inside {64'h400, 64'h2000, 64'h4000})) code = 2;
                else if ((longint'(a0) % (n * 4)) != 0) code = 1;
                else begin fwd = 1; eop = 2; ewa = longint'(a0 >> 2); ecnt = n; end
            end
            8'h35, 8'h36: begin
                tag = "R10";
                if (n == 0 || n > 8) code = 2;
                else begin fwd = 1; eop = (opc == 8'h35) ? 3 : 4; ecnt = pw; edev = longint'(a0[7:0]); end
            end
            default: begin fwd = 1; eop = 5; edev = longint'(a0[7:0]); end
        endcase
    endtask

    // Drive one command, sample its registered outcome, compare and update model.
    task automatic send(input logic [7:0] opc, input logic [10:0] len, input logic [1:0] cl,
                        input logic [31:0] a0, input logic [31:0] a1, input logic busy,
                        output int got);
        int code, eop; bit fwd; longint ewa, ecnt, edev; string tag;
        model(opc, len, cl, a0, a1, busy, code, fwd, eop, ewa, ecnt, edev, tag);
        @(negedge clk);
        cmd_valid = 1; cmd_opcode = opc; cmd_len = len; cmd_client = cl;
        cmd_arg0 = a0; cmd_arg1 = a1; cfg_busy = busy;
        @(negedge clk);
        cmd_valid = 0; cfg_busy = 0;
        check("R1", "rsp_valid", longint'(rsp_valid), 1);
        check(tag, "rsp_code", longint'(rsp_code), longint'(code));
        check(tag, "req_valid", longint'(req_valid), longint'(fwd));
        if (fwd && req_valid) begin
            check(tag, "req_op", longint'(req_op), longint'(eop));
            check(tag, "req_waddr", longint'(req_waddr), ewa);
            check(tag, "req_count", longint'(req_count), ecnt);
            check(tag, "req_devop", longint'(req_devop), edev);
            check("R9", "req_cs", longint'(req_cs), longint'(m_cs));
        end
        if (code == 0) begin
            if (opc == 8'h32) begin m_owner_v = 1; m_owner = cl; end
            if (opc == 8'h33) m_owner_v = 0;
            if (opc == 8'h34) m_cs = a0[29:28];
        end
        got = int'(rsp_code);
    endtask

    task automatic expect_code(input string tag, input int got, input int want);
        check(tag, "directed code", longint'(got), longint'(want));
    endtask

    function automatic logic [10:0] nominal_len(input logic [7:0] opc, input logic [31:0] a1);
        case (opc)
            8'h32, 8'h33: return 11'd0;
            8'h34, 8'h37: return 11'd1;
            8'h39:        return 11'(a1 + 2);
            8'h36:        return 11'(((a1 + 3) >> 2) + 2);
            default:      return 11'd2;
        endcase
    endfunction

    initial begin
        int c;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R13: idle outputs after reset
        check("R13", "rsp_valid", longint'(rsp_valid), 0);
        check("R13", "req_valid", longint'(req_valid), 0);
        check("R13", "rsp_code", longint'(rsp_code), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1", "no command no rsp", longint'(rsp_valid), 0);

        send(8'h3A, 2, 1, 32'h100, 4, 0, c);           expect_code("R3", c, 4);
        send(8'h32, 0, 1, 0, 0, 1, c);                 expect_code("R2", c, 3);
        send(8'h32, 0, 1, 0, 0, 0, c);                 expect_code("R2", c, 0);
        send(8'h32, 0, 1, 0, 0, 0, c);                 expect_code("R2", c, 0);
        send(8'h32, 0, 2, 0, 0, 0, c);                 expect_code("R2", c, 3);
        send(8'h3A, 2, 2, 32'h100, 4, 0, c);           expect_code("R3", c, 4);
        send(8'h3A, 2, 1, 32'h102, 4, 0, c);           expect_code("R7", c, 1);
        send(8'h3A, 2, 1, 32'h100, 1025, 0, c);        expect_code("R6", c, 2);
        send(8'h3A, 2, 1, 32'h100, 0, 0, c);           expect_code("R6", c, 2);
        send(8'h3A, 2, 1, 32'h100, 1024, 0, c);        expect_code("R11", c, 0);
        check("R11", "read waddr", longint'(req_waddr), 64'h40);
        send(8'h3A, 2, 1, 32'h100, 4, 1, c);           expect_code("R5", c, 3);
        send(8'h39, 6, 1, 32'h200, 4, 1, c);           expect_code("R5", c, 3);
        send(8'h39, 5, 1, 32'h200, 4, 0, c);           expect_code("R4", c, 5);
        send(8'h39, 6, 1, 32'h200, 4, 0, c);           expect_code("R11", c, 0);
        send(8'h38, 2, 1, 32'h8000, 32'h2000, 0, c);   expect_code("R8", c, 0);
        send(8'h38, 2, 1, 32'h1000, 32'h2000, 0, c);   expect_code("R8", c, 1);
        send(8'h38, 2, 1, 32'h1000, 32'h400, 0, c);    expect_code("R8", c, 0);
        send(8'h38, 2, 1, 32'h8000, 32'h4000, 0, c);   expect_code("R8", c, 1);
        send(8'h38, 2, 1, 32'h0, 32'h800, 0, c);       expect_code("R8", c, 2);
        send(8'h34, 1, 1, 32'h1000_0000, 0, 0, c);     expect_code("R9", c, 7);
        send(8'h34, 1, 1, 32'h0FFF_FFFF, 0, 0, c);     expect_code("R9", c, 0);
        send(8'h35, 2, 1, 32'h9F, 5, 0, c);            expect_code("R10", c, 0);
        check("R10", "padded words", longint'(req_count), 2);
        send(8'h35, 2, 1, 32'h9F, 9, 0, c);            expect_code("R10", c, 2);
        send(8'h36, 4, 1, 32'hDC, 6, 0, c);            expect_code("R10", c, 0);
        send(8'h36, 3, 1, 32'hDC, 6, 0, c);            expect_code("R4", c, 5);
        send(8'h37, 1, 1, 32'h06, 0, 0, c);            expect_code("R11", c, 0);
        send(8'h3B, 2, 1, 32'h0, 1, 0, c);             expect_code("R1", c, 6);
        send(8'h3A, 3, 2, 32'h100, 4, 1, c);           expect_code("R12", c, 4);
        send(8'h3A, 3, 1, 32'h101, 0, 1, c);           expect_code("R12", c, 5);
        send(8'h3A, 2, 1, 32'h101, 0, 1, c);           expect_code("R12", c, 3);
        send(8'h3A, 2, 1, 32'h101, 0, 0, c);           expect_code("R12", c, 2);
        send(8'h33, 0, 2, 0, 0, 0, c);                 expect_code("R3", c, 4);
        send(8'h33, 0, 1, 0, 0, 0, c);                 expect_code("R3", c, 0);
        send(8'h32, 0, 2, 0, 0, 0, c);                 expect_code("R3", c, 0);

        // constrained random mix against the model
        for (int i = 0; i < 800; i++) begin
            logic [7:0]  opc;
            logic [31:0] a0, a1;
            logic [1:0]  cl;
            logic [10:0] len;
            logic        busy;
            case ($urandom % 12)
                0: opc = 8'h32; 1: opc = 8'h33; 2: opc = 8'h34; 3: opc = 8'h35;
                4: opc = 8'h36; 5: opc = 8'h37; 6, 7: opc = 8'h38; 8: opc = 8'h39;
                9, 10: opc = 8'h3A; default: opc = 8'(8'h30 + $urandom % 16);
            endcase
            case ($urandom % 9)
                0: a1 = 0; 1: a1 = 1; 2: a1 = 1024; 3: a1 = 1025;
                4: a1 = 32'h400; 5: a1 = 32'h2000; 6: a1 = 32'h4000;
                7: a1 = $urandom % 12; default: a1 = $urandom % 2048;
            endcase
            case ($urandom % 5)
                0: a0 = $urandom & 32'hFFFF_0000;
                1: a0 = $urandom & 32'hFFFF_F000;
                2: a0 = $urandom & 32'hFFFF_FFFC;
                3: a0 = $urandom & 32'h0FFF_FFFF;
                default: a0 = $urandom;
            endcase
            cl   = (m_owner_v && ($urandom % 4 != 0)) ? m_owner : 2'($urandom);
            len  = ($urandom % 4 != 0) ? nominal_len(opc, a1) : 11'($urandom % 8);
            busy = ($urandom % 8 == 0);
            send(opc, len, cl, a0, a1, busy, c);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule